// File: doc/BRIEF.md
# Dual-Clock Burst Static Memory

This block is a true two-port static memory. It has a left port and a right port. Each port runs on its own clock and can reach any word at any time, including the word the other port is using. On its own clock edge, each port captures its address, write data, chip selects, direction and byte-lane controls into input registers. A write is stored into the array on the following edge of that port's clock.

Each port has a burst address counter. The counter can be loaded from the address pins, stepped by one every cycle, held, or cleared to zero, so a stream of words can be transferred after one address has been given. A per-port mode pin chooses the read timing. In flow-through timing, data follows the capturing edge. In pipelined timing, data arrives one edge later through an output register. Each port has two chip selects of opposite polarity, so banks can be stacked in depth without external decoding. Each port also has two byte-lane write enables. An output-enable pin decides only whether the port drives its data pins. The read data and a drive flag are brought out separately so the pad ring can build the tri-state buffer. The full array size is 16 address bits with 18-bit or 16-bit words, and is set through parameters.

Top module: `dual_burst_ram`

## Requirements
- R1: A port is selected only when its `sel_n` is low and its `sel` is high. At a deselected capturing edge, no write happens and that access does not drive the outputs.
- R2: When `read` is high, a selected access reads. When `read` is low, it writes `wdata` at the captured address. Data written by one port can be read back later by either port.
- R3: With `pipe` low, read data and `drive` are valid after the edge that captured the read. They hold until the next edge.
- R4: With `pipe` high, read data and `drive` appear one port-clock edge later than in R3.
- R5: `lo_n` and `hi_n` are active-low write enables. `lo_n` covers bits [LANE_W-1:0] and `hi_n` covers bits [2*LANE_W-1:LANE_W]. A lane whose enable is high keeps its stored value.
- R6: When `load_n` is low at an edge (and `zero_n` is high), the access address becomes the value on `addr`.
- R7: When `load_n` is high, `step_n` is low and `zero_n` is high, the access address increments by one each edge. It wraps from the top address to zero.
- R8: When `zero_n`, `load_n` and `step_n` are all high, the access address holds.
- R9: When `zero_n` is low, the access address becomes zero. This takes priority over loading and stepping.
- R10: While `oe_n` is high, `drive` is low and `rdata` is zero. `oe_n` does not change stored data or the counter.
- R11: If one port reads a word in the same cycle that the other port writes it, the reader gets the old contents. Both ports may read the same word at once.
- R12: While `rst_n` is low and after its release, the access address is zero and neither port drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of port registers |
| l_clk | input | 1 | Left port clock |
| l_sel_n | input | 1 | Left active-low chip select |
| l_sel | input | 1 | Left active-high chip select |
| l_read | input | 1 | Left direction, 1 read, 0 write |
| l_hi_n | input | 1 | Left upper-lane write enable, active low |
| l_lo_n | input | 1 | Left lower-lane write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_load_n | input | 1 | Left counter load from address, active low |
| l_step_n | input | 1 | Left counter increment, active low |
| l_zero_n | input | 1 | Left counter clear, active low |
| l_pipe | input | 1 | Left read timing, 1 pipelined |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data, zero when not driving |
| l_drive | output | 1 | Left pad drive enable |
| r_clk | input | 1 | Right port clock |
| r_sel_n | input | 1 | Right active-low chip select |
| r_sel | input | 1 | Right active-high chip select |
| r_read | input | 1 | Right direction, 1 read, 0 write |
| r_hi_n | input | 1 | Right upper-lane write enable, active low |
| r_lo_n | input | 1 | Right lower-lane write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_load_n | input | 1 | Right counter load from address, active low |
| r_step_n | input | 1 | Right counter increment, active low |
| r_zero_n | input | 1 | Right counter clear, active low |
| r_pipe | input | 1 | Right read timing, 1 pipelined |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data, zero when not driving |
| r_drive | output | 1 | Right pad drive enable |

## Verification
The first pattern fills words through one port and reads them back through both ports, one in flow-through and one in pipelined timing. This separates a one-edge latency error from a two-edge one. Bursts loaded near the top address, then stepped, held and cleared with several counter pins asserted at once, show whether the counter's priority order and wrap are right. Single-lane writes show whether the lane enables are swapped or ignored. A write on one port during a read of the same word on the other port shows whether the array gives old-data or write-through behaviour. The same patterns run with chip selects inactive or output enable high, which shows whether those pins gate the write or only the pad drive.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

    // Counter action chosen at each port clock edge; listed lowest to highest priority.
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_STEP = 2'd1,
        CNT_LOAD = 2'd2,
        CNT_ZERO = 2'd3
    } cnt_op_e;

    function automatic cnt_op_e pick_op(input logic zero_n, input logic load_n,
                                        input logic step_n);
        if (!zero_n) return CNT_ZERO;
        if (!load_n) return CNT_LOAD;
        if (!step_n) return CNT_STEP;
        return CNT_HOLD;
    endfunction

endpackage

// File: rtl/dpr_port_ctl.sv
`timescale 1ns/1ps
// Input registers and burst counter of one port.
module dpr_port_ctl
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_n,
    input  logic                     sel,
    input  logic                     rd_mode,
    input  logic [LANES-1:0]         lane_n,
    input  logic                     load_n,
    input  logic                     step_n,
    input  logic                     zero_n,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic [LANES*LANE_W-1:0]  wdata_in,
    output logic [ADDR_W-1:0]        acc_addr,
    output logic                     acc_wr,
    output logic                     acc_rd,
    output logic [LANES-1:0]         acc_lanes,
    output logic [LANES*LANE_W-1:0]  acc_data
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              rd;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t st_d, st_q;
    logic picked;

    always_comb begin
        st_d   = st_q;
        picked = !sel_n && sel;
        unique case (pick_op(zero_n, load_n, step_n))
            CNT_ZERO: st_d.addr = '0;
            CNT_LOAD: st_d.addr = addr_in;
            CNT_STEP: st_d.addr = st_q.addr + ADDR_W'(1);
            default:  st_d.addr = st_q.addr;
        endcase
        st_d.wr    = picked && !rd_mode;
        st_d.rd    = picked && rd_mode;
        st_d.lanes = ~lane_n;
        st_d.data  = wdata_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_addr  = st_q.addr;
    assign acc_wr    = st_q.wr;
    assign acc_rd    = st_q.rd;
    assign acc_lanes = st_q.lanes;
    assign acc_data  = st_q.data;

    // R9
    zero_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_n |=> acc_addr == '0);
    // R6
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && !load_n) |=> acc_addr == $past(addr_in));
    // R7
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && load_n && !step_n) |=> acc_addr == ADDR_W'($past(acc_addr) + 1'b1));
    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && load_n && step_n) |=> $stable(acc_addr));
    // R1
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !sel) |=> !acc_wr && !acc_rd);
    // R2
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({acc_wr, acc_rd}) <= 1);

endmodule

// File: rtl/dpr_core.sv
`timescale 1ns/1ps
// Two-clock storage array. Each port owns a bank; per-lane toggle bits record which bank holds the newest write.
module dpr_core #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk_l,
    input  logic [ADDR_W-1:0]        addr_l,
    input  logic                     wr_l,
    input  logic [LANES-1:0]         lanes_l,
    input  logic [LANES*LANE_W-1:0]  data_l,
    output logic [LANES*LANE_W-1:0]  word_l,
    input  logic                     clk_r,
    input  logic [ADDR_W-1:0]        addr_r,
    input  logic                     wr_r,
    input  logic [LANES-1:0]         lanes_r,
    input  logic [LANES*LANE_W-1:0]  data_r,
    output logic [LANES*LANE_W-1:0]  word_r
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] bank_l [DEPTH][LANES];
    logic [LANE_W-1:0] bank_r [DEPTH][LANES];
    logic              tog_l  [DEPTH][LANES];
    logic              tog_r  [DEPTH][LANES];

    // Left writer makes its toggle differ from the right one.
    always_ff @(posedge clk_l) begin
        if (wr_l) begin
            for (int k = 0; k < LANES; k++) begin
                if (lanes_l[k]) begin
                    bank_l[addr_l][k] <= data_l[k*LANE_W +: LANE_W];
                    tog_l[addr_l][k]  <= ~tog_r[addr_l][k];
                end
            end
        end
    end

    // Right writer makes its toggle equal to the left one.
    always_ff @(posedge clk_r) begin
        if (wr_r) begin
            for (int k = 0; k < LANES; k++) begin
                if (lanes_r[k]) begin
                    bank_r[addr_r][k] <= data_r[k*LANE_W +: LANE_W];
                    tog_r[addr_r][k]  <= tog_l[addr_r][k];
                end
            end
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            word_l[k*LANE_W +: LANE_W] = (tog_l[addr_l][k] != tog_r[addr_l][k])
                                       ? bank_l[addr_l][k] : bank_r[addr_l][k];
            word_r[k*LANE_W +: LANE_W] = (tog_l[addr_r][k] != tog_r[addr_r][k])
                                       ? bank_l[addr_r][k] : bank_r[addr_r][k];
        end
    end

endmodule

// File: rtl/dpr_out_stage.sv
`timescale 1ns/1ps
// Read timing select and pad drive control of one port.
module dpr_out_stage #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe,
    input  logic              oe_n,
    input  logic              rd_sel,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata,
    output logic              drive
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t st_d, st_q;
    logic have;

    always_comb begin
        st_d.vld  = rd_sel;
        st_d.data = word;
        have  = pipe ? st_q.vld : rd_sel;
        drive = !oe_n && have;
        rdata = drive ? (pipe ? st_q.data : word) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive && rdata == '0);
    // R3
    flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && !oe_n && rd_sel) |-> drive && rdata == word);
    // R4
    pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && !oe_n) |-> drive == $past(rd_sel));
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> rdata == '0);

endmodule

// File: rtl/dual_burst_ram.sv
`timescale 1ns/1ps
// Two-port synchronous burst memory. Index 0 is the left port, 1 the right port.
module dual_burst_ram #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic                  rst_n,
    input  logic                  l_clk,
    input  logic                  l_sel_n,
    input  logic                  l_sel,
    input  logic                  l_read,
    input  logic                  l_hi_n,
    input  logic                  l_lo_n,
    input  logic                  l_oe_n,
    input  logic                  l_load_n,
    input  logic                  l_step_n,
    input  logic                  l_zero_n,
    input  logic                  l_pipe,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [2*LANE_W-1:0]   l_wdata,
    output logic [2*LANE_W-1:0]   l_rdata,
    output logic                  l_drive,
    input  logic                  r_clk,
    input  logic                  r_sel_n,
    input  logic                  r_sel,
    input  logic                  r_read,
    input  logic                  r_hi_n,
    input  logic                  r_lo_n,
    input  logic                  r_oe_n,
    input  logic                  r_load_n,
    input  logic                  r_step_n,
    input  logic                  r_zero_n,
    input  logic                  r_pipe,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [2*LANE_W-1:0]   r_wdata,
    output logic [2*LANE_W-1:0]   r_rdata,
    output logic                  r_drive
);
    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;
    localparam int NPORT  = 2;

    logic [NPORT-1:0]  clk_v, sel_n_v, sel_v, rd_v, oe_n_v, load_n_v, step_n_v, zero_n_v, pipe_v;
    logic [LANES-1:0]  lane_n_v [NPORT];
    logic [ADDR_W-1:0] addr_v   [NPORT];
    logic [DATA_W-1:0] wdata_v  [NPORT];

    logic [ADDR_W-1:0] acc_addr  [NPORT];
    logic [NPORT-1:0]  acc_wr, acc_rd;
    logic [LANES-1:0]  acc_lanes [NPORT];
    logic [DATA_W-1:0] acc_data  [NPORT];
    logic [DATA_W-1:0] word_v    [NPORT];
    logic [DATA_W-1:0] rdata_v   [NPORT];
    logic [NPORT-1:0]  drive_v;

    assign clk_v    = {r_clk,    l_clk};
    assign sel_n_v  = {r_sel_n,  l_sel_n};
    assign sel_v    = {r_sel,    l_sel};
    assign rd_v     = {r_read,   l_read};
    assign oe_n_v   = {r_oe_n,   l_oe_n};
    assign load_n_v = {r_load_n, l_load_n};
    assign step_n_v = {r_step_n, l_step_n};
    assign zero_n_v = {r_zero_n, l_zero_n};
    assign pipe_v   = {r_pipe,   l_pipe};
    assign lane_n_v[0] = {l_hi_n, l_lo_n};
    assign lane_n_v[1] = {r_hi_n, r_lo_n};
    assign addr_v[0]   = l_addr;
    assign addr_v[1]   = r_addr;
    assign wdata_v[0]  = l_wdata;
    assign wdata_v[1]  = r_wdata;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpr_port_ctl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctl (
            .clk      (clk_v[p]),
            .rst_n    (rst_n),
            .sel_n    (sel_n_v[p]),
            .sel      (sel_v[p]),
            .rd_mode  (rd_v[p]),
            .lane_n   (lane_n_v[p]),
            .load_n   (load_n_v[p]),
            .step_n   (step_n_v[p]),
            .zero_n   (zero_n_v[p]),
            .addr_in  (addr_v[p]),
            .wdata_in (wdata_v[p]),
            .acc_addr (acc_addr[p]),
            .acc_wr   (acc_wr[p]),
            .acc_rd   (acc_rd[p]),
            .acc_lanes(acc_lanes[p]),
            .acc_data (acc_data[p])
        );

        dpr_out_stage #(.DATA_W(DATA_W)) u_out (
            .clk    (clk_v[p]),
            .rst_n  (rst_n),
            .pipe   (pipe_v[p]),
            .oe_n   (oe_n_v[p]),
            .rd_sel (acc_rd[p]),
            .word   (word_v[p]),
            .rdata  (rdata_v[p]),
            .drive  (drive_v[p])
        );
    end

    dpr_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_core (
        .clk_l  (l_clk),
        .addr_l (acc_addr[0]),
        .wr_l   (acc_wr[0]),
        .lanes_l(acc_lanes[0]),
        .data_l (acc_data[0]),
        .word_l (word_v[0]),
        .clk_r  (r_clk),
        .addr_r (acc_addr[1]),
        .wr_r   (acc_wr[1]),
        .lanes_r(acc_lanes[1]),
        .data_r (acc_data[1]),
        .word_r (word_v[1])
    );

    assign l_rdata = rdata_v[0];
    assign r_rdata = rdata_v[1];
    assign l_drive = drive_v[0];
    assign r_drive = drive_v[1];

    // R12
    reset_quiet_chk: assert property (@(posedge l_clk) $rose(rst_n) |-> !l_drive && !r_drive);

endmodule

// File: tb/dual_burst_ram_test.sv
`timescale 1ns/1ps
module dual_burst_ram_test;
    localparam int AW    = 10;
    localparam int LW    = 9;
    localparam int DW    = 2 * LW;
    localparam int DEPTH = 1 << AW;
    localparam real HALF = 2.5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(HALF) clk = ~clk;

    logic sel_n [2], sel [2], rd [2], hi_n [2], lo_n [2], oe_n [2];
    logic ld_n [2], st_n [2], zr_n [2], pipe [2];
    logic [AW-1:0] ad [2];
    logic [DW-1:0] wd [2];
    logic [DW-1:0] rdq [2];
    logic          drv [2];

    dual_burst_ram #(.ADDR_W(AW), .LANE_W(LW)) uut (
        .rst_n(rst_n),
        .l_clk(clk), .l_sel_n(sel_n[0]), .l_sel(sel[0]), .l_read(rd[0]),
        .l_hi_n(hi_n[0]), .l_lo_n(lo_n[0]), .l_oe_n(oe_n[0]), .l_load_n(ld_n[0]),
        .l_step_n(st_n[0]), .l_zero_n(zr_n[0]), .l_pipe(pipe[0]), .l_addr(ad[0]),
        .l_wdata(wd[0]), .l_rdata(rdq[0]), .l_drive(drv[0]),
        .r_clk(clk), .r_sel_n(sel_n[1]), .r_sel(sel[1]), .r_read(rd[1]),
        .r_hi_n(hi_n[1]), .r_lo_n(lo_n[1]), .r_oe_n(oe_n[1]), .r_load_n(ld_n[1]),
        .r_step_n(st_n[1]), .r_zero_n(zr_n[1]), .r_pipe(pipe[1]), .r_addr(ad[1]),
        .r_wdata(wd[1]), .r_rdata(rdq[1]), .r_drive(drv[1])
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string tag = "R12";

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [DW-1:0] mm [DEPTH];
    logic [1:0]    km [DEPTH];
    logic [AW-1:0] m_ad [2];
    bit            m_rd [2], m_wr [2], m_pv [2];
    bit   [1:0]    m_ln [2], m_pk [2];
    logic [DW-1:0] m_dt [2], m_pd [2];
    logic [DW-1:0] n_d [2];
    bit   [1:0]    n_k [2];
    bit            n_v [2];

    initial for (int i = 0; i < DEPTH; i++) km[i] = 2'b00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_ad[p] = '0; m_rd[p] = 0; m_wr[p] = 0; m_pv[p] = 0;
                m_ln[p] = 0; m_pk[p] = 0; m_dt[p] = '0; m_pd[p] = '0;
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                n_d[p] = mm[m_ad[p]]; n_k[p] = km[m_ad[p]]; n_v[p] = m_rd[p];
            end
            for (int p = 0; p < 2; p++)
                if (m_wr[p])
                    for (int k = 0; k < 2; k++)
                        if (m_ln[p][k]) begin
                            mm[m_ad[p]][k*LW +: LW] = m_dt[p][k*LW +: LW];
                            km[m_ad[p]][k] = 1'b1;
                        end
            for (int p = 0; p < 2; p++) begin
                m_pd[p] = n_d[p]; m_pk[p] = n_k[p]; m_pv[p] = n_v[p];
                if (!zr_n[p])      m_ad[p] = '0;
                else if (!ld_n[p]) m_ad[p] = ad[p];
                else if (!st_n[p]) m_ad[p] = m_ad[p] + 1'b1;
                m_wr[p] = !sel_n[p] && sel[p] && !rd[p];
                m_rd[p] = !sel_n[p] && sel[p] && rd[p];
                m_ln[p] = ~{hi_n[p], lo_n[p]};
                m_dt[p] = wd[p];
            end
        end
    end

    // Compare every cycle, 1.5 ns after the falling edge.
    always begin
        @(negedge clk);
        #1.5;
        if (rst_n && !finished) begin
            for (int p = 0; p < 2; p++) begin
                logic          ed;
                logic [DW-1:0] edat, mask;
                bit   [1:0]    ek;
                string lat;
                lat  = pipe[p] ? "R4" : "R3";
                ed   = !oe_n[p] && (pipe[p] ? m_pv[p] : m_rd[p]);
                edat = pipe[p] ? m_pd[p] : mm[m_ad[p]];
                ek   = pipe[p] ? m_pk[p] : km[m_ad[p]];
                mask = {{LW{ek[1]}}, {LW{ek[0]}}};
                check($sformatf("%s/%s port%0d drive", tag, lat, p), 64'(drv[p]), 64'(ed));
                if (!ed)
                    check($sformatf("%s/R10 port%0d idle data", tag, p), 64'(rdq[p]), 64'd0);
                else if (ek != 2'b00)
                    check($sformatf("%s/%s port%0d data", tag, lat, p),
                          64'(rdq[p] & mask), 64'(edat & mask));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int p);
        sel_n[p] = 1; sel[p] = 0; rd[p] = 1; hi_n[p] = 1; lo_n[p] = 1;
        ld_n[p] = 1; st_n[p] = 1; zr_n[p] = 1; ad[p] = '0; wd[p] = '0;
    endtask

    // mode: 0 read, 1 write both lanes
    task automatic acc(int p, bit wr, bit ld, bit st, logic [AW-1:0] a, logic [DW-1:0] d);
        sel_n[p] = 0; sel[p] = 1; rd[p] = !wr; hi_n[p] = !wr; lo_n[p] = !wr;
        ld_n[p] = !ld; st_n[p] = !st; zr_n[p] = 1; ad[p] = a; wd[p] = d;
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            idle(p); oe_n[p] = 0; pipe[p] = 0;
        end
        tick(3);
        // R12: no drive while reset is held
        check("R12 left drive in reset", 64'(drv[0]), 64'd0);
        check("R12 right drive in reset", 64'(drv[1]), 64'd0);
        rst_n = 1;
        tick(1);
        check("R12 left drive after reset", 64'(drv[0]), 64'd0);

        // R2: left fills words 0..15, read back by both ports, right pipelined
        tag = "R2";
        for (int i = 0; i < 16; i++) begin acc(0, 1, 1, 0, AW'(i), DW'(18'h1000 + i * 7)); tick(); end
        acc(0, 1, 1, 0, AW'(DEPTH - 1), 18'h2ABCD); tick();
        idle(0); pipe[1] = 1; tick();
        for (int i = 0; i < 16; i++) begin
            acc(0, 0, 1, 0, AW'(15 - i), '0);
            acc(1, 0, 1, 0, AW'(i), '0);
            tick();
        end
        idle(0); idle(1); tick(2);

        // R6 / R7: load then step a read burst on the right, step a write burst on the left
        tag = "R7";
        acc(1, 0, 1, 0, AW'(4), '0); tick();
        for (int i = 0; i < 5; i++) begin acc(1, 0, 0, 1, '0, '0); tick(); end
        acc(0, 1, 1, 0, AW'(20), 18'h0F0F0); tick();
        for (int i = 0; i < 6; i++) begin acc(0, 1, 0, 1, '0, DW'(18'h03300 + i)); tick(); end
        // R8: counter holds with all counter pins high
        tag = "R8";
        for (int i = 0; i < 3; i++) begin acc(1, 0, 0, 0, AW'(9), '0); tick(); end
        // R7: wrap from top address
        tag = "R7";
        acc(1, 0, 1, 0, AW'(DEPTH - 1), '0); tick();
        acc(1, 0, 0, 1, '0, '0); tick();
        acc(0, 0, 1, 0, AW'(20), '0); tick();
        for (int i = 0; i < 6; i++) begin acc(0, 0, 0, 1, '0, '0); tick(); end
        // R9: clear wins over load and step
        tag = "R9";
        acc(1, 0, 1, 1, AW'(7), '0); zr_n[1] = 0; tick();
        acc(1, 0, 0, 0, '0, '0); tick();
        // R6: plain load after clear
        tag = "R6";
        acc(1, 0, 1, 0, AW'(13), '0); tick();
        idle(0); idle(1); tick(2);

        // R5: single-lane writes
        tag = "R5";
        acc(0, 1, 1, 0, AW'(3), 18'h3FFFF); hi_n[0] = 1; tick();
        acc(0, 1, 1, 0, AW'(5), 18'h15555); lo_n[0] = 1; tick();
        acc(0, 1, 1, 0, AW'(6), 18'h3FFFF); hi_n[0] = 1; lo_n[0] = 1; tick();
        idle(0); pipe[1] = 0;
        for (int i = 3; i < 7; i++) begin acc(1, 0, 1, 0, AW'(i), '0); tick(); end
        idle(1); tick(2);

        // R1: writes attempted with one select inactive, then read back
        tag = "R1";
        acc(0, 1, 1, 0, AW'(2), 18'h00BAD); sel_n[0] = 1; tick();
        acc(0, 1, 1, 0, AW'(2), 18'h00BAD); sel[0] = 0; tick();
        acc(0, 0, 1, 0, AW'(2), '0); sel_n[0] = 1; tick();
        idle(0); acc(1, 0, 1, 0, AW'(2), '0); tick();
        idle(1); tick(2);

        // R10: output enable high hides reads, then reveals unchanged data
        tag = "R10";
        oe_n[0] = 1; pipe[0] = 1;
        for (int i = 8; i < 12; i++) begin acc(0, 0, 1, 0, AW'(i), '0); tick(); end
        oe_n[0] = 0; acc(0, 0, 0, 0, '0, '0); tick(2);
        idle(0); pipe[0] = 0; tick(2);

        // R11: cross-port read during write of the same word, then both read it
        tag = "R11";
        acc(0, 1, 1, 0, AW'(12), 18'h2468A);
        acc(1, 0, 1, 0, AW'(12), '0); tick();
        acc(1, 0, 0, 0, '0, '0); idle(0); tick();
        acc(1, 1, 1, 0, AW'(40), 18'h13579);
        acc(0, 0, 1, 0, AW'(40), '0); pipe[0] = 1; tick();
        acc(0, 0, 0, 0, '0, '0); acc(1, 0, 1, 0, AW'(40), '0); tick(3);
        idle(0); idle(1); tick(3);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule